// File: doc/BRIEF.md
# Masked Interrupt-on-Change Controller

This block watches a bank of digital input pins and drives one shared interrupt request whenever an enabled pin changes level, rising or falling. Each pin passes through a two-flop synchroniser, and an edge is found by comparing the synchronised level with its value one cycle earlier. An enable mask, one bit per pin, decides which pins may raise the request.

When the request fires, the block takes two snapshots in the same clock cycle: the set of pins whose edge caused it, and the synchronised level of every pin. Both snapshots stay frozen while the request is pending, so software always reads a consistent pair. Enabled edges that arrive while the request is pending are collected and kept. A one-cycle clear strobe acknowledges the request. If edges were collected in the meantime, the request comes back one cycle later with a fresh snapshot.

Top module: `ioc_ctrl`

## Requirements
- R1: An input change reaches the interrupt through two synchroniser flops and one history flop. A pin driven to a new level just after a clock edge raises `irq_o` after the third rising edge that follows, and not earlier.
- R2: A pin whose `mask_i` bit is 0 never raises `irq_o`, and its edges are not collected.
- R3: Rising and falling transitions both count. At capture, bit i of `edge_snap_o` is 1 exactly when enabled pin i changed since the previous capture or clear.
- R4: At capture, `level_snap_o` takes the synchronised level of every pin, masked or not, in the same cycle as `edge_snap_o`.
- R5: `irq_o` is a level. It stays 1 until a cycle with `clr_i` = 1 and falls after that edge. A `clr_i` pulse while `irq_o` = 0 changes neither `irq_o` nor the snapshots.
- R6: While `irq_o` is 1, both snapshots hold still even if pins change. Enabled edges seen in that time are kept in a pending set. After a clear, the snapshots keep their values until the next capture.
- R7: If the pending set is not empty at the clear, `irq_o` is 0 for one cycle and then returns to 1. The new edge snapshot holds only the pending edges, and the new level snapshot holds the current levels.
- R8: Setting a mask bit from 0 to 1 on a pin that is steady creates no edge. Only transitions that occur after the bit is set count.
- R9: Synchronous active-high reset clears `irq_o`, both snapshots, the pending set and the synchroniser history to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | PIN_COUNT | Digital inputs, may be asynchronous |
| mask_i | input | PIN_COUNT | Per-pin interrupt enable, 1 = enabled |
| clr_i | input | 1 | Interrupt clear strobe, active high for one cycle |
| irq_o | output | 1 | Shared interrupt request, level |
| edge_snap_o | output | PIN_COUNT | Pins whose edge caused the current capture |
| level_snap_o | output | PIN_COUNT | Pin levels at the current capture |

## Verification
The checker tests on every cycle that the request holds as a level until a clear, that a clear always drops it, that a capture never happens with an empty edge snapshot, that the snapshots do not move while the request is pending, and that a fully masked bank with nothing pending never raises it. Only the bench scenarios can show the exact three-edge latency, the bit-exact edge and level contents for mixed rising and falling patterns, the rearm after a clear with collected edges, and that enabling a steady pin creates no false edge.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    // Capture engine: free to capture, or holding a snapshot until cleared
    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;

    localparam int unsigned SYNC_DEPTH_DEFAULT = 2;
    localparam int unsigned PIN_COUNT_DEFAULT  = 8;

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int unsigned WIDTH  = ioc_pkg::PIN_COUNT_DEFAULT,
    parameter int unsigned STAGES = ioc_pkg::SYNC_DEPTH_DEFAULT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain[s] <= '0;
                    else       chain[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain[s] <= '0;
                    else       chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[LAST];

endmodule

// File: rtl/ioc_edge_detect.sv
module ioc_edge_detect #(
    parameter int unsigned WIDTH = ioc_pkg::PIN_COUNT_DEFAULT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] enable_i,
    output logic [WIDTH-1:0] hit_o
);

    logic [WIDTH-1:0] history_q;
    logic [WIDTH-1:0] toggled;

    // History follows the level on every pin regardless of the enable,
    // so turning an enable on never compares against a stale value.
    always_ff @(posedge clk_i) begin
        if (rst_i) history_q <= '0;
        else       history_q <= level_i;
    end

    generate
        for (genvar p = 0; p < WIDTH; p++) begin : g_pin
            assign toggled[p] = level_i[p] ^ history_q[p];
            assign hit_o[p]   = toggled[p] & enable_i[p];
        end
    endgenerate

endmodule

// File: rtl/ioc_capture.sv
module ioc_capture
    import ioc_pkg::*;
#(
    parameter int unsigned WIDTH = ioc_pkg::PIN_COUNT_DEFAULT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] hit_i,
    input  logic [WIDTH-1:0] level_i,
    input  logic             clr_i,
    output logic             irq_o,
    output logic [WIDTH-1:0] edge_snap_o,
    output logic [WIDTH-1:0] level_snap_o,
    output logic             pend_any_o
);

    typedef struct packed {
        logic [WIDTH-1:0] edges;
        logic [WIDTH-1:0] levels;
    } snap_t;

    cap_state_e       state_q;
    snap_t            snap_q;
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] gather;

    assign gather = pend_q | hit_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= CAP_IDLE;
            snap_q  <= '0;
            pend_q  <= '0;
        end else begin
            unique case (state_q)
                CAP_IDLE: begin
                    if (|gather) begin
                        snap_q.edges  <= gather;
                        snap_q.levels <= level_i;
                        pend_q        <= '0;
                        state_q       <= CAP_HELD;
                    end
                end
                CAP_HELD: begin
                    pend_q <= gather;
                    if (clr_i) state_q <= CAP_IDLE;
                end
                default: state_q <= CAP_IDLE;
            endcase
        end
    end

    assign irq_o        = (state_q == CAP_HELD);
    assign edge_snap_o  = snap_q.edges;
    assign level_snap_o = snap_q.levels;
    assign pend_any_o   = |pend_q;

endmodule

// File: rtl/ioc_ctrl.sv
module ioc_ctrl #(
    parameter int unsigned PIN_COUNT  = ioc_pkg::PIN_COUNT_DEFAULT,
    parameter int unsigned SYNC_DEPTH = ioc_pkg::SYNC_DEPTH_DEFAULT
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [PIN_COUNT-1:0] pin_i,
    input  logic [PIN_COUNT-1:0] mask_i,
    input  logic                 clr_i,
    output logic                 irq_o,
    output logic [PIN_COUNT-1:0] edge_snap_o,
    output logic [PIN_COUNT-1:0] level_snap_o
);

    logic [PIN_COUNT-1:0] pin_sync;
    logic [PIN_COUNT-1:0] pin_hit;
    logic                 pend_any;

    ioc_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_DEPTH)) i_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    ioc_edge_detect #(.WIDTH(PIN_COUNT)) i_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .level_i  (pin_sync),
        .enable_i (mask_i),
        .hit_o    (pin_hit)
    );

    ioc_capture #(.WIDTH(PIN_COUNT)) i_cap (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .hit_i        (pin_hit),
        .level_i      (pin_sync),
        .clr_i        (clr_i),
        .irq_o        (irq_o),
        .edge_snap_o  (edge_snap_o),
        .level_snap_o (level_snap_o),
        .pend_any_o   (pend_any)
    );

endmodule

// File: rtl/ioc_ctrl_chk.sv
module ioc_ctrl_chk #(
    parameter int unsigned PIN_COUNT = ioc_pkg::PIN_COUNT_DEFAULT
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic [PIN_COUNT-1:0] mask_i,
    input logic                 clr_i,
    input logic                 irq_o,
    input logic [PIN_COUNT-1:0] edge_snap_o,
    input logic [PIN_COUNT-1:0] level_snap_o,
    input logic                 pend_any
);

    // R5: request is a level held until a clear
    p_irq_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !clr_i) |=> irq_o);

    // R5: a clear always drops the request for at least one cycle
    p_clear_drop_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && clr_i) |=> !irq_o);

    // R3: a capture always records at least one edge
    p_snap_nonzero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !$past(irq_o)) |-> (edge_snap_o != '0));

    // R6: snapshots frozen while pending
    p_snap_frozen_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |=> ($stable(edge_snap_o) && $stable(level_snap_o)));

    // R2: fully masked bank with nothing collected never raises the request
    p_mask_block_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!irq_o && !pend_any && (mask_i == '0)) |=> !irq_o);

    // R9: reset leaves the request and snapshots cleared
    p_reset_clear_r9: assert property (@(posedge clk_i)
        rst_i |=> (!irq_o && (edge_snap_o == '0) && (level_snap_o == '0)));

endmodule

bind ioc_ctrl ioc_ctrl_chk #(.PIN_COUNT(PIN_COUNT)) i_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .mask_i       (mask_i),
    .clr_i        (clr_i),
    .irq_o        (irq_o),
    .edge_snap_o  (edge_snap_o),
    .level_snap_o (level_snap_o),
    .pend_any     (pend_any)
);

// File: tb/test_ioc_ctrl.sv
`timescale 1ns/1ps
module test_ioc_ctrl;

    localparam int unsigned N = 8;

    logic         clk_i = 1'b0;
    logic         rst_i = 1'b1;
    logic [N-1:0] pin_i = '0;
    logic [N-1:0] mask_i = '0;
    logic         clr_i = 1'b0;
    logic         irq_o;
    logic [N-1:0] edge_snap_o;
    logic [N-1:0] level_snap_o;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    always #4 clk_i = ~clk_i;

    ioc_ctrl #(.PIN_COUNT(N)) i_ioc_ctrl (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .pin_i        (pin_i),
        .mask_i       (mask_i),
        .clr_i        (clr_i),
        .irq_o        (irq_o),
        .edge_snap_o  (edge_snap_o),
        .level_snap_o (level_snap_o)
    );

    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] pins;
        logic         irq;
        logic [N-1:0] edges;
        logic [N-1:0] levels;
    } vec_t;

    // Each vector: drive mask and pins, expect irq and snapshots 3 edges later
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{mask: 8'hFF, pins: 8'h01, irq: 1'b1, edges: 8'h01, levels: 8'h01}, // R3 rise
        '{mask: 8'hFF, pins: 8'h03, irq: 1'b1, edges: 8'h02, levels: 8'h03}, // R4
        '{mask: 8'h0F, pins: 8'hF3, irq: 1'b0, edges: 8'h02, levels: 8'h03}, // R2
        '{mask: 8'hFF, pins: 8'hF2, irq: 1'b1, edges: 8'h01, levels: 8'hF2}, // R3 fall, R8
        '{mask: 8'hFF, pins: 8'h0D, irq: 1'b1, edges: 8'hFF, levels: 8'h0D}, // R3 mixed
        '{mask: 8'h00, pins: 8'hF2, irq: 1'b0, edges: 8'hFF, levels: 8'h0D}, // R2
        '{mask: 8'h80, pins: 8'h72, irq: 1'b1, edges: 8'h80, levels: 8'h72}  // R4 unmasked levels
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_clear();
        clr_i = 1'b1;
        tick(1);
        clr_i = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            tests_failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        @(negedge clk_i);
        tick(3);
        rst_i = 1'b0;
        check("R9", "irq after reset", {31'd0, irq_o}, 32'd0);
        check("R9", "edge snap after reset", {24'd0, edge_snap_o}, 32'd0);
        check("R9", "level snap after reset", {24'd0, level_snap_o}, 32'd0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            mask_i = VEC[v].mask;
            pin_i  = VEC[v].pins;
            if (v == 0) begin
                tick(2);
                check("R1", "irq before third edge", {31'd0, irq_o}, 32'd0);
                tick(1);
            end else begin
                tick(3);
            end
            check("R3", $sformatf("vec %0d irq", v), {31'd0, irq_o}, {31'd0, VEC[v].irq});
            check("R3", $sformatf("vec %0d edges", v), {24'd0, edge_snap_o}, {24'd0, VEC[v].edges});
            check("R4", $sformatf("vec %0d levels", v), {24'd0, level_snap_o}, {24'd0, VEC[v].levels});
            if (VEC[v].irq) pulse_clear();
            else tick(1);
            tick(1);
            check("R5", $sformatf("vec %0d irq after clear", v), {31'd0, irq_o}, 32'd0);
        end

        // Pending edges during a held request, then rearm
        rst_i = 1'b1; pin_i = '0; mask_i = '0;
        tick(2);
        rst_i = 1'b0;
        check("R9", "irq after second reset", {31'd0, irq_o}, 32'd0);
        mask_i = 8'hFF;
        pin_i  = 8'h01;
        tick(3);
        check("R1", "irq on third edge", {31'd0, irq_o}, 32'd1);
        pin_i = 8'h03;
        tick(4);
        check("R5", "irq held without clear", {31'd0, irq_o}, 32'd1);
        check("R6", "edges frozen", {24'd0, edge_snap_o}, 32'h01);
        check("R6", "levels frozen", {24'd0, level_snap_o}, 32'h01);
        pulse_clear();
        check("R7", "irq low one cycle after clear", {31'd0, irq_o}, 32'd0);
        tick(1);
        check("R7", "irq rearmed", {31'd0, irq_o}, 32'd1);
        check("R7", "fresh edges", {24'd0, edge_snap_o}, 32'h02);
        check("R7", "fresh levels", {24'd0, level_snap_o}, 32'h03);
        pulse_clear();
        tick(2);
        check("R7", "no rearm when nothing pending", {31'd0, irq_o}, 32'd0);
        check("R6", "edges kept after clear", {24'd0, edge_snap_o}, 32'h02);

        // Clear while idle has no effect
        pulse_clear();
        tick(1);
        check("R5", "idle clear irq", {31'd0, irq_o}, 32'd0);
        check("R5", "idle clear edges", {24'd0, edge_snap_o}, 32'h02);
        check("R5", "idle clear levels", {24'd0, level_snap_o}, 32'h03);

        // Enabling a steady pin creates no edge
        mask_i = 8'h00;
        pin_i  = 8'h83;
        tick(5);
        check("R2", "masked rise ignored", {31'd0, irq_o}, 32'd0);
        mask_i = 8'hFF;
        tick(5);
        check("R8", "enable of steady pin", {31'd0, irq_o}, 32'd0);
        pin_i = 8'h03;
        tick(3);
        check("R8", "later edge counts", {31'd0, irq_o}, 32'd1);
        check("R8", "later edge bits", {24'd0, edge_snap_o}, 32'h80);
        check("R4", "later edge levels", {24'd0, level_snap_o}, 32'h03);

        // Reset while request pending
        rst_i = 1'b1; pin_i = '0;
        tick(1);
        check("R9", "reset drops irq", {31'd0, irq_o}, 32'd0);
        check("R9", "reset clears edges", {24'd0, edge_snap_o}, 32'd0);
        check("R9", "reset clears levels", {24'd0, level_snap_o}, 32'd0);
        rst_i = 1'b0;
        tick(5);
        check("R9", "no edge after reset release", {31'd0, irq_o}, 32'd0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule